// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block translates data-side virtual addresses to physical addresses through a table of 64 fully associative entries. Every entry carries its own page size (8 KB, 64 KB, 512 KB or 4 MB). An entry also holds an address space context, a global flag and a set of access attributes. A lookup gives a 64-bit virtual address, a context selector, an access kind and the user/kernel level. One cycle later the block answers with a 41-bit physical address and read/write permission, or else with a miss, a data-access fault or a write-protection trap.

The block keeps three status registers. The fault status register records the cause of the last fault. The fault address register holds the faulting virtual address. The tag access register holds the page-aligned virtual address joined with the context of the last fault or miss. Entries are written one at a time through an indexed write port, which also clears that entry's used flag. Choosing which entry to replace and walking the page tables belong to the surrounding logic. When translation is switched off, addresses pass straight through.

Top module: `mpsz_dtlb`

## Requirements
- R1: After reset, no response is pending, the fault status, fault address and tag access registers read zero, every entry is invalid (any translated lookup misses) and every used flag reads 0.
- R2: An entry's 2-bit size code sets how many low address bits the compare ignores: 0 ignores 13 bits (8 KB), 1 ignores 16 (64 KB), 2 ignores 19 (512 KB) and 3 ignores 22 (4 MB). An address one page above the entry misses.
- R3: An entry matches only if it is valid, its address matches under its mask, and it is global or its 13-bit context equals the lookup context. Selector 0 takes `prim_ctx`, selector 1 takes `sec_ctx`, and selectors 2 and 3 (nucleus) take context 0.
- R4: On a hit, the physical address is made of the entry's address bits at and above the mask boundary, with the lookup address bits below it. The result is cut to 41 bits and its low 13 bits are cleared.
- R5: When several entries match, the one with the lowest index is used.
- R6: On a match, each of three fault bits is set if its condition holds: status bit 7 for a user access to a privileged page, bit 8 for a non-faulting load (kind 2) to a side-effect page, and bit 9 for any other kind to a page marked non-faulting-only. Any set bit gives `rsp_dfault`. Access kinds: 0 load, 1 store, 2 non-faulting load, 3 treated as load.
- R7: If no fault bit applies but the access is a store and the entry is not writable, `rsp_prot` is raised instead.
- R8: A successful translated hit sets the entry's used flag and grants read permission. It grants write permission only if the entry is writable. A fault does not set the used flag.
- R9: On a fault or protection trap, the fault status register is replaced by: bit 0 valid, bit 2 store, bit 3 non-faulting load, bit 4 kernel access, bits 6:5 context type (0 primary, 1 secondary, 2 nucleus), bits 9:7 fault bits. The fault address register takes the lookup address. The tag access register takes the lookup address with bits 12:0 replaced by the lookup context.
- R10: The overflow bit (status bit 1) is set by a fault only if the status register was valid and was not cleared by `fsr_clear` in that cycle. `fsr_clear` zeroes the status register.
- R11: On a miss, `rsp_miss` is raised and only the tag access register changes. Fault status and fault address keep their values.
- R12: With `xlat_en` low, a lookup hits with the lookup address cut to 41 bits (no bits cleared), with read and write permission, and no status register changes.
- R13: A write to an entry and a lookup in the same cycle: the lookup sees the old contents, and the write leaves the entry's used flag at 0.
- R14: Each lookup gives exactly one response, one cycle later, with exactly one of hit, miss, fault or protection. No response appears without a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlat_en | input | 1 | Translation enable |
| prim_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_va | input | 64 | Entry virtual address |
| wr_ctx | input | 13 | Entry context |
| wr_pa | input | 41 | Entry physical address |
| wr_size | input | 2 | Entry page size code |
| wr_valid | input | 1 | Entry valid |
| wr_global | input | 1 | Entry ignores context |
| wr_priv | input | 1 | Entry is kernel-only |
| wr_writable | input | 1 | Entry permits stores |
| wr_side_eff | input | 1 | Entry has side effects |
| wr_nf_only | input | 1 | Entry is for non-faulting loads only |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx_sel | input | 2 | Context selector |
| lk_kind | input | 2 | Access kind |
| lk_user | input | 1 | User-level access |
| fsr_clear | input | 1 | Clear fault status |
| probe_idx | input | 6 | Entry whose used flag is shown |
| probe_used | output | 1 | Used flag of the probed entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation granted |
| rsp_miss | output | 1 | No entry matched |
| rsp_dfault | output | 1 | Data-access fault |
| rsp_prot | output | 1 | Write-protection trap |
| rsp_pa | output | 41 | Physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| fsr | output | 10 | Fault status register |
| far | output | 64 | Fault address register |
| tag_access | output | 64 | Tag access register |

## Verification
A lookup and an entry write to the same index can land in the same cycle. The lookup must then return the old translation, and the write must win over the used-flag update that the hit would cause. The bench drives both on one falling edge. It compares the returned address with the old mapping, reads the probed used flag as 0, and then checks that the next lookup returns the new mapping. A second overlap is a fault arriving while the status register is still valid; this is judged through the overflow bit, once with a clear in between and once without.

// File: rtl/mpsz_dtlb.sv
module mpsz_dtlb #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13,
  parameter int PG_LSB  = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        xlat_en,
  input  logic [CTX_W-1:0]            prim_ctx,
  input  logic [CTX_W-1:0]            sec_ctx,
  input  logic                        wr_en,
  input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
  input  logic [VA_W-1:0]             wr_va,
  input  logic [CTX_W-1:0]            wr_ctx,
  input  logic [PA_W-1:0]             wr_pa,
  input  logic [1:0]                  wr_size,
  input  logic                        wr_valid,
  input  logic                        wr_global,
  input  logic                        wr_priv,
  input  logic                        wr_writable,
  input  logic                        wr_side_eff,
  input  logic                        wr_nf_only,
  input  logic                        lk_valid,
  input  logic [VA_W-1:0]             lk_va,
  input  logic [1:0]                  lk_ctx_sel,
  input  logic [1:0]                  lk_kind,
  input  logic                        lk_user,
  input  logic                        fsr_clear,
  input  logic [$clog2(ENTRIES)-1:0]  probe_idx,
  output logic                        probe_used,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic                        rsp_miss,
  output logic                        rsp_dfault,
  output logic                        rsp_prot,
  output logic [PA_W-1:0]             rsp_pa,
  output logic                        rsp_rd,
  output logic                        rsp_wr,
  output logic [9:0]                  fsr,
  output logic [VA_W-1:0]             far,
  output logic [VA_W-1:0]             tag_access
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [1:0] K_STORE = 2'd1;
  localparam logic [1:0] K_NFLD  = 2'd2;
  localparam logic [PA_W-1:0] PA_ALIGN = {{(PA_W-PG_LSB){1'b1}}, {PG_LSB{1'b0}}};

  logic [VA_W-1:0]  e_va  [ENTRIES];
  logic [CTX_W-1:0] e_ctx [ENTRIES];
  logic [PA_W-1:0]  e_pa  [ENTRIES];
  logic [1:0]       e_size[ENTRIES];
  logic [ENTRIES-1:0] e_valid, e_used, e_global, e_priv, e_wok, e_se, e_nfo;

  function automatic logic [VA_W-1:0] size_mask(input logic [1:0] sz);
    return {VA_W{1'b1}} << (PG_LSB + 3 * int'(sz));
  endfunction

  logic [CTX_W-1:0] cur_ctx;
  logic [1:0]       ctx_type;
  always_comb begin
    case (lk_ctx_sel)
      2'd0:    begin cur_ctx = prim_ctx;     ctx_type = 2'd0; end
      2'd1:    begin cur_ctx = sec_ctx;      ctx_type = 2'd1; end
      default: begin cur_ctx = '0;           ctx_type = 2'd2; end
    endcase
  end

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = e_valid[g]
                   && (((lk_va ^ e_va[g]) & size_mask(e_size[g])) == '0)
                   && (e_global[g] || (e_ctx[g] == cur_ctx));
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  wire            any_hit  = |match;
  wire [VA_W-1:0] s_mask   = size_mask(e_size[sel]);
  wire [VA_W-1:0] pa_wide  = ({{(VA_W-PA_W){1'b0}}, e_pa[sel]} & s_mask) | (lk_va & ~s_mask);
  wire [PA_W-1:0] pa_hit   = pa_wide[PA_W-1:0] & PA_ALIGN;

  wire f_priv = e_priv[sel] && lk_user;
  wire f_se   = (lk_kind == K_NFLD) && e_se[sel];
  wire f_nfo  = (lk_kind != K_NFLD) && e_nfo[sel];
  wire f_any  = f_priv | f_se | f_nfo;
  wire f_prot = !f_any && (lk_kind == K_STORE) && !e_wok[sel];

  wire       ovf     = fsr[0] && !fsr_clear;
  wire [9:0] fsr_new = {f_nfo, f_se, f_priv, ctx_type, !lk_user,
                        lk_kind == K_NFLD, lk_kind == K_STORE, ovf, 1'b1};
  wire [VA_W-1:0] tag_new = {lk_va[VA_W-1:CTX_W], cur_ctx};

  assign probe_used = e_used[probe_idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_va[wr_idx]   <= wr_va;
      e_ctx[wr_idx]  <= wr_ctx;
      e_pa[wr_idx]   <= wr_pa;
      e_size[wr_idx] <= wr_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= '0; e_used <= '0; e_global <= '0; e_priv <= '0;
      e_wok <= '0; e_se <= '0; e_nfo <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0;
      rsp_dfault <= 1'b0; rsp_prot <= 1'b0; rsp_pa <= '0;
      rsp_rd <= 1'b0; rsp_wr <= 1'b0;
      fsr <= '0; far <= '0; tag_access <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_dfault <= 1'b0;
      rsp_prot   <= 1'b0;
      rsp_pa     <= '0;
      rsp_rd     <= 1'b0;
      rsp_wr     <= 1'b0;
      if (fsr_clear) fsr <= '0;
      if (lk_valid) begin
        if (!xlat_en) begin
          rsp_hit <= 1'b1;
          rsp_pa  <= lk_va[PA_W-1:0];
          rsp_rd  <= 1'b1;
          rsp_wr  <= 1'b1;
        end else if (!any_hit) begin
          rsp_miss   <= 1'b1;
          tag_access <= tag_new;
        end else if (f_any || f_prot) begin
          rsp_dfault <= f_any;
          rsp_prot   <= f_prot;
          fsr        <= fsr_new;
          far        <= lk_va;
          tag_access <= tag_new;
        end else begin
          rsp_hit     <= 1'b1;
          rsp_pa      <= pa_hit;
          rsp_rd      <= 1'b1;
          rsp_wr      <= e_wok[sel];
          e_used[sel] <= 1'b1;
        end
      end
      if (wr_en) begin
        e_valid[wr_idx]  <= wr_valid;
        e_global[wr_idx] <= wr_global;
        e_priv[wr_idx]   <= wr_priv;
        e_wok[wr_idx]    <= wr_writable;
        e_se[wr_idx]     <= wr_side_eff;
        e_nfo[wr_idx]    <= wr_nf_only;
        e_used[wr_idx]   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpsz_dtlb_chk.sv
module mpsz_dtlb_chk #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 41,
  parameter int PG_LSB = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xlat_en,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_va,
  input logic            fsr_clear,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_dfault,
  input logic            rsp_prot,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_wr,
  input logic [9:0]      fsr,
  input logic [VA_W-1:0] far
);
  assert_one_outcome_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_dfault, rsp_prot}) == 1);

  assert_idle_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_dfault || rsp_prot));

  assert_lookup_answered_R14: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_miss_keeps_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> $stable(far) && ($stable(fsr) || $past(fsr_clear)));

  assert_dfault_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_dfault |-> fsr[0] && (fsr[9:7] != 3'b000));

  assert_prot_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot |-> fsr[2] && (fsr[9:7] == 3'b000) && !rsp_wr);

  assert_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_dfault || rsp_prot) |-> fsr[1] == ($past(fsr[0]) && !$past(fsr_clear)));

  assert_fault_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_dfault || rsp_prot) |-> far == $past(lk_va));

  assert_page_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && $past(xlat_en)) |-> rsp_pa[PG_LSB-1:0] == '0);
endmodule

bind mpsz_dtlb mpsz_dtlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_LSB(PG_LSB)) chk_i (
  .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .lk_valid(lk_valid), .lk_va(lk_va),
  .fsr_clear(fsr_clear), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_dfault(rsp_dfault), .rsp_prot(rsp_prot), .rsp_pa(rsp_pa), .rsp_wr(rsp_wr),
  .fsr(fsr), .far(far)
);

// File: tb/mpsz_dtlb_tb_top.sv
module mpsz_dtlb_tb_top;
  localparam logic [12:0] PRIM = 13'h055;
  localparam logic [12:0] SEC  = 13'h077;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic xlat_en = 1'b0, wr_en = 1'b0, lk_valid = 1'b0, lk_user = 1'b0, fsr_clear = 1'b0;
  logic [12:0] prim_ctx = PRIM, sec_ctx = SEC, wr_ctx = '0;
  logic [5:0]  wr_idx = '0, probe_idx = '0;
  logic [63:0] wr_va = '0, lk_va = '0;
  logic [40:0] wr_pa = '0;
  logic [1:0]  wr_size = '0, lk_ctx_sel = '0, lk_kind = '0;
  logic wr_valid = 1'b0, wr_global = 1'b0, wr_priv = 1'b0, wr_writable = 1'b0;
  logic wr_side_eff = 1'b0, wr_nf_only = 1'b0;
  logic probe_used, rsp_valid, rsp_hit, rsp_miss, rsp_dfault, rsp_prot, rsp_rd, rsp_wr;
  logic [40:0] rsp_pa;
  logic [9:0]  fsr;
  logic [63:0] far, tag_access;

  mpsz_dtlb dut_i (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .prim_ctx(prim_ctx), .sec_ctx(sec_ctx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_va(wr_va), .wr_ctx(wr_ctx), .wr_pa(wr_pa),
    .wr_size(wr_size), .wr_valid(wr_valid), .wr_global(wr_global), .wr_priv(wr_priv),
    .wr_writable(wr_writable), .wr_side_eff(wr_side_eff), .wr_nf_only(wr_nf_only),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_ctx_sel(lk_ctx_sel), .lk_kind(lk_kind),
    .lk_user(lk_user), .fsr_clear(fsr_clear), .probe_idx(probe_idx), .probe_used(probe_used),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_dfault(rsp_dfault),
    .rsp_prot(rsp_prot), .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .fsr(fsr), .far(far), .tag_access(tag_access)
  );

  typedef struct {
    int          kind;
    logic [40:0] pa;
    bit          rd, wr;
    logic [9:0]  fsr;
    logic [63:0] far, tag;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [9:0]  m_fsr = '0;
  logic [63:0] m_far = '0, m_tag = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // kinds: 0 hit, 1 miss, 2 data fault, 3 protection
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        check(0, "R14", "response without lookup", 1, 0);
      end else begin
        exp_t e;
        int ak;
        e = q.pop_front();
        ak = rsp_hit ? 0 : rsp_miss ? 1 : rsp_dfault ? 2 : rsp_prot ? 3 : 9;
        check(ak == e.kind, e.req, "outcome", 64'(ak), 64'(e.kind));
        check(rsp_pa == e.pa, e.req, "pa", 64'(rsp_pa), 64'(e.pa));
        check(rsp_rd == e.rd && rsp_wr == e.wr, e.req, "rd/wr",
              64'({rsp_rd, rsp_wr}), 64'({e.rd, e.wr}));
        check(fsr == e.fsr, e.req, "fsr", 64'(fsr), 64'(e.fsr));
        check(far == e.far, e.req, "far", far, e.far);
        check(tag_access == e.tag, e.req, "tag_access", tag_access, e.tag);
      end
    end
  end

  task automatic wr_drive(input int idx, input logic [63:0] va, input logic [12:0] cx,
                          input logic [40:0] pa, input logic [1:0] sz, input logic [5:0] fl);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_va = va; wr_ctx = cx; wr_pa = pa; wr_size = sz;
    {wr_valid, wr_global, wr_priv, wr_writable, wr_side_eff, wr_nf_only} = fl;
  endtask

  task automatic wr_entry(input int idx, input logic [63:0] va, input logic [12:0] cx,
                          input logic [40:0] pa, input logic [1:0] sz, input logic [5:0] fl);
    @(negedge clk);
    wr_drive(idx, va, cx, pa, sz, fl);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lk_drive(input logic [63:0] va, input logic [1:0] cs, input logic [1:0] k,
                          input bit u, input int ek, input logic [40:0] epa, input bit ewr,
                          input logic [2:0] fb, input string req);
    exp_t e;
    logic [12:0] cx;
    logic [1:0]  ct;
    lk_valid = 1'b1; lk_va = va; lk_ctx_sel = cs; lk_kind = k; lk_user = u;
    cx = (cs == 2'd0) ? PRIM : (cs == 2'd1) ? SEC : 13'h0;
    ct = (cs == 2'd0) ? 2'd0 : (cs == 2'd1) ? 2'd1 : 2'd2;
    if (xlat_en) begin
      if (ek == 1) m_tag = {va[63:13], cx};
      else if (ek >= 2) begin
        m_fsr = {fb, ct, !u, k == 2'd2, k == 2'd1, m_fsr[0], 1'b1};
        m_far = va;
        m_tag = {va[63:13], cx};
      end
    end
    e.kind = ek; e.pa = (ek == 0) ? epa : '0; e.rd = (ek == 0); e.wr = (ek == 0) ? ewr : 1'b0;
    e.fsr = m_fsr; e.far = m_far; e.tag = m_tag; e.req = req;
    q.push_back(e);
  endtask

  task automatic lookup(input logic [63:0] va, input logic [1:0] cs, input logic [1:0] k,
                        input bit u, input int ek, input logic [40:0] epa, input bit ewr,
                        input logic [2:0] fb, input string req);
    @(negedge clk);
    lk_drive(va, cs, k, u, ek, epa, ewr, fb, req);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic probe(input int idx, input bit exp, input string req);
    probe_idx = 6'(idx);
    #1;
    check(probe_used == exp, req, "used flag", 64'(probe_used), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 0);
    check(fsr == '0 && far == '0 && tag_access == '0, "R1", "status regs",
          64'(fsr) | far | tag_access, 0);
    probe(0, 0, "R1");
    xlat_en = 1'b1;
    lookup(64'h0000_1234_5678_1ABC, 2'd0, 2'd0, 1, 1, '0, 0, 3'b000, "R1");

    // R2/R4/R8: 8 KB entry at index 0
    wr_entry(0, 64'h0000_1234_5678_0000, PRIM, 41'h0AB_CDEF_3FFF, 2'd0, 6'b100100);
    lookup(64'h0000_1234_5678_1ABC, 2'd0, 2'd0, 1, 0, 41'h0AB_CDEF_2000, 1, 3'b000, "R4");
    probe(0, 1, "R8");
    lookup(64'h0000_1234_5678_2000, 2'd0, 2'd0, 1, 1, '0, 0, 3'b000, "R2");
    lookup(64'h0000_1234_5678_0000, 2'd1, 2'd0, 1, 1, '0, 0, 3'b000, "R3");

    // R3: global 4 MB read-only entry
    wr_entry(7, 64'h0000_0000_4000_0000, 13'h003, 41'h100_0041_1111, 2'd3, 6'b110000);
    lookup(64'h0000_0000_402A_5123, 2'd2, 2'd0, 0, 0, 41'h100_006A_4000, 0, 3'b000, "R3");
    // R7/R9: store to read-only page
    lookup(64'h0000_0000_402A_5123, 2'd2, 2'd1, 0, 3, '0, 0, 3'b000, "R7");
    check(m_fsr == 10'h055, "R9", "model fsr", 64'(m_fsr), 64'h055);

    // R6/R10: 64 KB privileged, side-effect, nf-only entry
    wr_entry(12, 64'h0000_0000_0080_0000, SEC, 41'h0_3330_0000, 2'd1, 6'b101111);
    lookup(64'h0000_0000_0080_F008, 2'd1, 2'd0, 1, 2, '0, 0, 3'b101, "R10");
    probe(12, 0, "R8");
    @(negedge clk); fsr_clear = 1'b1; m_fsr = '0;
    @(negedge clk); fsr_clear = 1'b0;
    check(fsr == '0, "R10", "fsr after clear", 64'(fsr), 0);
    lookup(64'h0000_0000_0080_0010, 2'd1, 2'd2, 0, 2, '0, 0, 3'b010, "R6");

    // R2: 512 KB entry and its boundary; R11: miss leaves fsr/far
    wr_entry(20, 64'h0000_0000_0100_0000, PRIM, 41'h0_0200_0000, 2'd2, 6'b100100);
    lookup(64'h0000_0000_0107_E100, 2'd0, 2'd1, 1, 0, 41'h0_0207_E000, 1, 3'b000, "R2");
    lookup(64'h0000_0000_0108_0000, 2'd0, 2'd0, 1, 1, '0, 0, 3'b000, "R11");

    // R5: lowest index wins
    wr_entry(9, 64'h0000_0000_2000_0000, PRIM, 41'h0_0005_5000, 2'd0, 6'b100100);
    wr_entry(4, 64'h0000_0000_2000_0000, PRIM, 41'h0_0004_4000, 2'd0, 6'b100100);
    lookup(64'h0000_0000_2000_0004, 2'd0, 2'd0, 1, 0, 41'h0_0004_4000, 1, 3'b000, "R5");
    probe(4, 1, "R5");
    probe(9, 0, "R5");

    // R13: write and lookup on the same entry in one cycle
    @(negedge clk);
    wr_drive(4, 64'h0000_0000_2000_0000, PRIM, 41'h0_0006_6000, 2'd0, 6'b100100);
    lk_drive(64'h0000_0000_2000_0004, 2'd0, 2'd0, 1, 0, 41'h0_0004_4000, 1, 3'b000, "R13");
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    probe(4, 0, "R13");
    lookup(64'h0000_0000_2000_0004, 2'd0, 2'd0, 1, 0, 41'h0_0006_6000, 1, 3'b000, "R13");

    // R12: translation disabled
    xlat_en = 1'b0;
    lookup(64'hFFFF_FFFF_FFFF_F123, 2'd0, 2'd1, 1, 0, 41'h1FF_FFFF_F123, 1, 3'b000, "R12");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R14", "unanswered lookups", 64'(q.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule